// File: doc/BRIEF.md
# Daisy-Chained Serial DAC Loader

This block sits on the host side of a chain of serial voltage-output converters. The converters share one serial clock line and one active-low load line. Each converter's serial output feeds the data input of the next one. When a start request is accepted, the block takes a snapshot of the N parallel 12-bit codes. It shifts all of them out on one data line, using a serial clock divided down from the system clock. After the last bit it holds the clock quiet and pulses the load line low once, so every converter's output changes at the same moment. Busy is high for the whole transaction, and a one-cycle done pulse ends it.

Code k in `codes_i` is meant for the converter at position k, where position 0 takes the block's data line directly. The bit stream that leaves the far end of the chain can be fed back on `sret_i`. An optional checker compares that stream with the words sent in the previous transaction and reports any difference.

The FSM has these states: `ST_IDLE`, `ST_CLK_LO` (clock low, bit presented), `ST_CLK_HI` (clock high), `ST_SETTLE` (wait before the strobe), `ST_STROBE` (load low), `ST_HOLD` (clock quiet after the strobe) and `ST_DONE`. It has these transitions:
- IDLE→CLK_LO on start.
- CLK_LO→CLK_HI when the half-period expires.
- CLK_HI→CLK_LO when the half-period expires and bits remain.
- CLK_HI→SETTLE after the last bit.
- SETTLE→STROBE, STROBE→HOLD and HOLD→DONE, each when its dwell expires.
- DONE→IDLE always.

Top module: `dacchain_loader`

## Requirements
- R1: An accepted start snapshots `codes_i`, where code k sits at bits [12k+11:12k]. Exactly N×12 rising serial-clock edges follow. The code for position N-1 goes first and each code goes most significant bit first, so after the strobe converter k holds code k.
- R2: The serial clock idles low. Each high half and each low half lasts Heff system cycles, where Heff = max(`half_i`, MIN_HALF). MIN_HALF = ceil(50 MHz / (2 × 1.4 MHz)) = 18, so the rate stays at or below 1.4 MHz. `half_i` is sampled at start.
- R3: `sdata_o` changes only while the serial clock is low, together with its falling edge, so it is stable for the whole high half.
- R4: `load_n_o` falls exactly Heff + LOAD_SETUP system cycles after the last rising serial edge. No rising serial edge occurs while `load_n_o` is low.
- R5: `load_n_o` stays low for LOAD_PERIODS × 2 × Heff system cycles.
- R6: `done_o` is a single-cycle pulse. It comes exactly HOLD_OFF cycles after `load_n_o` returns high, with the serial clock held low meanwhile. `busy_o` is high from the cycle after an accepted start through the done cycle, and low afterwards.
- R7: A start raised while busy has no effect, and so does a change of `codes_i` after acceptance. The transaction still makes N×12 edges, yields one done pulse and delivers the originally captured codes, and no new transaction follows.
- R8: `sret_i` is sampled just before each rising serial edge and compared, in order, with the bit stream of the previous transaction. `mismatch_o` is updated in the done cycle and then held. It is 1 if any sampled bit differed, and 0 if there has been no completed-start transaction since reset.
- R9: While reset is low, `sclk_o`=0, `load_n_o`=1, `busy_o`=0, `done_o`=0 and `mismatch_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only when idle |
| codes_i | input | N_DAC×CODE_W | Codes; code k at bits [CODE_W·k +: CODE_W] |
| half_i | input | DIV_W | Requested serial half-period in system cycles |
| sret_i | input | 1 | Data returned from the far end of the chain |
| sclk_o | output | 1 | Serial clock to all converters |
| sdata_o | output | 1 | Serial data to converter 0 |
| load_n_o | output | 1 | Shared active-low load strobe |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mismatch_o | output | 1 | Chain readback differed from previous words |

## Verification
The bench samples every output on the falling system edge and timestamps each transition. It then compares the distances between those timestamps with the arithmetic values:
- rise-to-rise distance is 2·Heff;
- high-half length is Heff;
- last rise to load fall is Heff+LOAD_SETUP;
- load width is LOAD_PERIODS·2·Heff;
- load rise to done is HOLD_OFF.

Busy is checked one sample after start, and both busy and the absence of further edges are checked in the samples after done. A behavioural chain of shift registers with transparent latches supplies the delivered codes and the returned stream. The returned stream can be inverted to provoke a mismatch, and `mismatch_o` is read in the done sample itself.

// File: rtl/dacchain_pkg.sv
package dacchain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_SETTLE,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } chain_state_e;

    function automatic int unsigned ceil_div(int unsigned num, int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/dacchain_dwell.sv
// Down-counting dwell timer: load with D-1, expire_o is high in the last cycle.
module dacchain_dwell #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_i) begin
            cnt_q <= ld_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/dacchain_piso.sv
// Parallel-in serial-out register for the whole chain, most significant bit first.
module dacchain_piso #(
    parameter int N_DAC  = 3,
    parameter int CODE_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic                      shift_i,
    input  logic [N_DAC*CODE_W-1:0]   data_i,
    output logic                      bit_o,
    output logic                      last_o
);
    localparam int TOTAL = N_DAC * CODE_W;
    localparam int IDX_W = (TOTAL > 2) ? $clog2(TOTAL) : 1;

    logic [TOTAL-1:0] sh_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            sh_q  <= data_i;
            idx_q <= '0;
        end else if (shift_i) begin
            sh_q  <= {sh_q[TOTAL-2:0], 1'b0};
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign bit_o  = sh_q[TOTAL-1];
    assign last_o = (idx_q == IDX_W'(TOTAL - 1));

    AST_NO_SHIFT_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |-> !last_o); // R1

endmodule

// File: rtl/dacchain_rbchk.sv
// Compares the stream returned from the chain end with the previous transaction's stream.
module dacchain_rbchk #(
    parameter int TOTAL    = 36,
    parameter bit CHECK_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [TOTAL-1:0] data_i,
    input  logic             sample_i,
    input  logic             sret_i,
    output logic             err_o
);
    generate
        if (CHECK_EN) begin : g_chk
            logic [TOTAL-1:0] cur_q;
            logic [TOTAL-1:0] exp_q;
            logic             have_q;
            logic             prev_ok_q;
            logic             err_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cur_q     <= '0;
                    exp_q     <= '0;
                    have_q    <= 1'b0;
                    prev_ok_q <= 1'b0;
                    err_q     <= 1'b0;
                end else if (load_i) begin
                    exp_q     <= cur_q;
                    cur_q     <= data_i;
                    prev_ok_q <= have_q;
                    have_q    <= 1'b1;
                    err_q     <= 1'b0;
                end else if (sample_i) begin
                    if (prev_ok_q && (sret_i != exp_q[TOTAL-1])) begin
                        err_q <= 1'b1;
                    end
                    exp_q <= {exp_q[TOTAL-2:0], 1'b0};
                end
            end

            assign err_o = err_q;

            AST_NO_ERR_WITHOUT_PREV: assert property (@(posedge clk) disable iff (!rst_n)
                !prev_ok_q |-> !err_q); // R8
        end else begin : g_nochk
            assign err_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/dacchain_loader.sv
module dacchain_loader
    import dacchain_pkg::*;
#(
    parameter int N_DAC        = 3,
    parameter int CODE_W       = 12,
    parameter int DIV_W        = 8,
    parameter int SYS_CLK_HZ   = 50_000_000,
    parameter int SCLK_MAX_HZ  = 1_400_000,
    parameter int LOAD_SETUP   = 3,
    parameter int LOAD_PERIODS = 1,
    parameter int HOLD_OFF     = 4,
    parameter bit CHECK_EN     = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [N_DAC*CODE_W-1:0] codes_i,
    input  logic [DIV_W-1:0]        half_i,
    input  logic                    sret_i,
    output logic                    sclk_o,
    output logic                    sdata_o,
    output logic                    load_n_o,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    mismatch_o
);
    localparam int TOTAL    = N_DAC * CODE_W;
    localparam int MIN_HALF = ceil_div(SYS_CLK_HZ, 2 * SCLK_MAX_HZ);
    localparam int CNT_A    = DIV_W + 1 + $clog2(LOAD_PERIODS + 1);
    localparam int CNT_B    = $clog2(LOAD_SETUP + HOLD_OFF + 2);
    localparam int CNT_W    = (CNT_A > CNT_B) ? CNT_A : CNT_B;

    chain_state_e     state_q, state_n;
    logic [DIV_W-1:0] h_q, h_eff;
    logic             h_ld;
    logic             tmr_ld, tmr_exp;
    logic [CNT_W-1:0] tmr_val, h_less, strobe_len;
    logic             piso_load, piso_shift, piso_last, piso_bit;
    logic             rb_sample, rb_err;

    logic sclk_q, load_n_q, busy_q, done_q, mism_q;

    // Serial half-period, clamped to the rate limit
    assign h_eff      = (half_i < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : half_i;
    assign h_less     = CNT_W'(h_q - DIV_W'(1));
    assign strobe_len = CNT_W'(LOAD_PERIODS) * CNT_W'({h_q, 1'b0});

    dacchain_dwell #(.CNT_W(CNT_W)) u_dwell (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (tmr_ld),
        .ld_val_i (tmr_val),
        .expire_o (tmr_exp)
    );

    dacchain_piso #(.N_DAC(N_DAC), .CODE_W(CODE_W)) u_piso (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (piso_load),
        .shift_i (piso_shift),
        .data_i  (codes_i),
        .bit_o   (piso_bit),
        .last_o  (piso_last)
    );

    dacchain_rbchk #(.TOTAL(TOTAL), .CHECK_EN(CHECK_EN)) u_rbchk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (piso_load),
        .data_i   (codes_i),
        .sample_i (rb_sample),
        .sret_i   (sret_i),
        .err_o    (rb_err)
    );

    // Next state and control strobes
    always_comb begin
        state_n    = state_q;
        tmr_ld     = 1'b0;
        tmr_val    = '0;
        piso_load  = 1'b0;
        piso_shift = 1'b0;
        rb_sample  = 1'b0;
        h_ld       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_n   = ST_CLK_LO;
                    tmr_ld    = 1'b1;
                    tmr_val   = CNT_W'(h_eff - DIV_W'(1));
                    piso_load = 1'b1;
                    h_ld      = 1'b1;
                end
            end
            ST_CLK_LO: begin
                if (tmr_exp) begin
                    state_n   = ST_CLK_HI;
                    tmr_ld    = 1'b1;
                    tmr_val   = h_less;
                    rb_sample = 1'b1;
                end
            end
            ST_CLK_HI: begin
                if (tmr_exp) begin
                    tmr_ld = 1'b1;
                    if (piso_last) begin
                        state_n = ST_SETTLE;
                        tmr_val = CNT_W'(LOAD_SETUP - 1);
                    end else begin
                        state_n    = ST_CLK_LO;
                        tmr_val    = h_less;
                        piso_shift = 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_exp) begin
                    state_n = ST_STROBE;
                    tmr_ld  = 1'b1;
                    tmr_val = strobe_len - CNT_W'(1);
                end
            end
            ST_STROBE: begin
                if (tmr_exp) begin
                    state_n = ST_HOLD;
                    tmr_ld  = 1'b1;
                    tmr_val = CNT_W'(HOLD_OFF - 1);
                end
            end
            ST_HOLD: begin
                if (tmr_exp) begin
                    state_n = ST_DONE;
                end
            end
            ST_DONE: begin
                state_n = ST_IDLE;
            end
            default: begin
                state_n = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            h_q     <= DIV_W'(MIN_HALF);
        end else begin
            state_q <= state_n;
            if (h_ld) begin
                h_q <= h_eff;
            end
        end
    end

    // Registered outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            load_n_q <= 1'b1;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            mism_q   <= 1'b0;
        end else begin
            sclk_q   <= (state_n == ST_CLK_HI);
            load_n_q <= (state_n != ST_STROBE);
            busy_q   <= (state_n != ST_IDLE);
            done_q   <= (state_n == ST_DONE);
            if (state_n == ST_DONE) begin
                mism_q <= rb_err;
            end
        end
    end

    assign sclk_o     = sclk_q;
    assign sdata_o    = piso_bit;
    assign load_n_o   = load_n_q;
    assign busy_o     = busy_q;
    assign done_o     = done_q;
    assign mismatch_o = mism_q;

    AST_LOAD_CLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n_o |-> !sclk_o); // R4
    AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdata_o)); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_DONE_LINES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (load_n_o && !sclk_o)); // R6
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o); // R6
    AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLK_HI && start_i) |=> (state_q != ST_IDLE)); // R7

endmodule

// File: tb/dacchain_loader_tb.sv
module dacchain_loader_tb;
    localparam int N     = 3;
    localparam int W     = 12;
    localparam int TOT   = N * W;
    localparam int DIVW  = 8;
    localparam int LSET  = 3;
    localparam int LPER  = 2;
    localparam int HOFF  = 5;
    localparam int MINH  = (50_000_000 + 2_800_000 - 1) / 2_800_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [TOT-1:0] codes = '0;
    logic [DIVW-1:0] half = '0;
    logic sret;
    logic sclk, sdata, load_n, busy, done, mism;

    always #10 clk = ~clk;

    dacchain_loader #(
        .N_DAC(N), .CODE_W(W), .DIV_W(DIVW), .LOAD_SETUP(LSET),
        .LOAD_PERIODS(LPER), .HOLD_OFF(HOFF), .CHECK_EN(1'b1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .codes_i(codes),
        .half_i(half), .sret_i(sret), .sclk_o(sclk), .sdata_o(sdata),
        .load_n_o(load_n), .busy_o(busy), .done_o(done), .mismatch_o(mism)
    );

    // Behavioural chain: shift registers plus transparent latches
    logic [TOT-1:0] chain = '0;
    logic [TOT-1:0] lat = '0;
    logic inj = 1'b0;
    always @(posedge sclk) chain <= {chain[TOT-2:0], sdata};
    assign sret = chain[TOT-1] ^ inj;
    always @(negedge clk) if (!load_n) lat <= chain;

    int checks = 0, errors = 0;
    int he = MINH;
    bit have_prev = 1'b0;

    // Monitor
    int cyc = 0, rises = 0, t_rise = 0, per_err = 0, hi_len = 0, hi_err = 0;
    int sd_err = 0, t_lf = 0, t_lr = 0, rise_in_load = 0, ndone = 0, t_done = 0;
    logic p_sclk = 1'b0, p_load = 1'b1, p_sdata = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (sclk && !p_sclk) begin
            if (rises > 0 && (cyc - t_rise) != 2 * he) per_err++;
            rises++;
            t_rise = cyc;
            if (!load_n) rise_in_load++;
        end
        if (sclk) hi_len++;
        if (!sclk && p_sclk) begin
            if (hi_len != he) hi_err++;
            hi_len = 0;
        end
        if (sclk && (sdata != p_sdata)) sd_err++;
        if (!load_n && p_load) t_lf = cyc;
        if (load_n && !p_load) t_lr = cyc;
        if (done) begin ndone++; t_done = cyc; end
        p_sclk = sclk; p_load = load_n; p_sdata = sdata;
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic clr_stats();
        rises = 0; per_err = 0; hi_len = 0; hi_err = 0; sd_err = 0;
        rise_in_load = 0; ndone = 0; t_rise = 0; t_lf = 0; t_lr = 0; t_done = 0;
    endtask

    task automatic wait_done(output bit ok);
        int n = 0;
        ok = 1'b0;
        while (n < 30000) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
            n++;
        end
    endtask

    task automatic run_txn(input logic [TOT-1:0] cv, input int hv, input bit injv, input bit mid_start);
        bit ok;
        logic [TOT-1:0] sent;
        bit exp_m;
        sent = cv;
        exp_m = have_prev && injv;
        he = (hv < MINH) ? MINH : hv;
        @(negedge clk);
        codes = cv; half = DIVW'(hv); inj = injv;
        clr_stats();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R6 busy after start", int'(busy), 1);
        half = DIVW'(MINH + 7);  // ignored after start (R2)
        if (mid_start) begin
            repeat (200) @(negedge clk);
            codes = ~cv; start = 1'b1;  // R7 ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(ok);
        chk(ok, "R6 done arrives (watchdog)", int'(ok), 1);
        #2;
        chk(rises == TOT, "R1 rising edge count", rises, TOT);
        chk(per_err == 0 && hi_err == 0, "R2 half periods", per_err + hi_err, 0);
        chk(sd_err == 0, "R3 data stable while clock high", sd_err, 0);
        chk(t_lf - t_rise == he + LSET, "R4 last rise to load fall", t_lf - t_rise, he + LSET);
        chk(rise_in_load == 0, "R4 no clock during load", rise_in_load, 0);
        chk(t_lr - t_lf == LPER * 2 * he, "R5 load width", t_lr - t_lf, LPER * 2 * he);
        chk(t_done - t_lr == HOFF, "R6 load rise to done", t_done - t_lr, HOFF);
        chk(mism == exp_m, "R8 mismatch flag", int'(mism), int'(exp_m));
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R6 idle after done", int'({busy, done}), 0);
        repeat (40) @(negedge clk);
        chk(rises == TOT && ndone == 1 && !busy, "R7 no extra transaction", rises * 10 + ndone, TOT * 10 + 1);
        for (int k = 0; k < N; k++) begin
            chk(lat[k*W +: W] == sent[k*W +: W], $sformatf("R1 converter %0d code", k),
                int'(lat[k*W +: W]), int'(sent[k*W +: W]));
        end
        codes = cv;
        have_prev = 1'b1;
        inj = 1'b0;
    endtask

    function automatic logic [TOT-1:0] pattern(input int i);
        logic [TOT-1:0] v;
        for (int k = 0; k < N; k++) v[k*W +: W] = W'((i * 1443 + k * 273 + 5) & 12'hFFF);
        return v;
    endfunction

    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        chk(!sclk && load_n && !busy && !done && !mism, "R9 reset state",
            int'({sclk, load_n, busy, done, mism}), int'(5'b01000));
        rst_n = 1'b1;
        run_txn('0, 0, 1'b1, 1'b0);                       // no previous: R8 expects 0
        run_txn({TOT{1'b1}}, 17, 1'b0, 1'b0);             // clamp to 18
        run_txn({12'hA5A, 12'h555, 12'hAAA}, 18, 1'b1, 1'b0);
        run_txn(pattern(1), 19, 1'b0, 1'b1);              // ignored start
        for (int i = 2; i < 6; i++) begin
            run_txn(pattern(i), 18 + i * 4, i[0], 1'b0);
        end
        run_txn({12'h800, 12'h001, 12'h800}, 40, 1'b0, 1'b0);
        // reset in the middle of a transaction
        @(negedge clk);
        codes = pattern(9); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (300) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!sclk && load_n && !busy && !done && !mism, "R9 reset mid-run",
            int'({sclk, load_n, busy, done, mism}), int'(5'b01000));
        have_prev = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_txn(pattern(10), 20, 1'b0, 1'b0);
        run_txn(pattern(11), 18, 1'b1, 1'b0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule